// File: doc/BRIEF.md
# GPIO port with interrupt detection

A 32-pin general-purpose I/O port with a simple register bus. Reads and writes take a single cycle. Each pin is an input or an output according to its direction bit. An output pin drives the value held in the data register. Whatever the direction, the level on the pad passes through a two-flop synchronizer and can be read back from a read-only pad level register.

Each pin also has an interrupt condition: a 2-bit trigger code that selects low level, high level, rising edge or falling edge. When a pin meets its condition it sets a sticky status bit, and software clears that bit by writing 1 to it. A mask register selects which pending bits raise an interrupt. Pins 0–15 drive one interrupt line and pins 16–31 drive another.

After reset every pin is an input and every interrupt is masked. The default trigger code is low level, so pins held low start setting status bits once reset is released. Software normally programs the trigger codes, clears the status register and only then unmasks.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, pad_oe_o and pad_o are 0, and both interrupt outputs are low.
- R2: Each register is selected by byte address: data 0x00, direction 0x04, pad level 0x08, trigger config for pins 0–15 at 0x0C, trigger config for pins 16–31 at 0x10, mask 0x14, status 0x18. Reads are combinational and written registers read back their value. Address 0x1C reads 0. A write to 0x08 changes nothing.
- R3: pad_oe_o equals the direction register (1 = output) and pad_o equals the data register, from the clock edge that follows the write.
- R4: The pad level register returns pad_i through two flops. A change applied between two edges is visible after the second of those edges, whatever the data register holds.
- R5: Trigger code 0 is low level and code 1 is high level. A pin with a level trigger sets its status bit on every edge while the synchronized level holds, so the bit comes back after a clear if the level persists.
- R6: Trigger code 2 is rising edge and code 3 is falling edge, found by comparing the synchronized level with its value one cycle earlier. A pad change applied between two edges shows in the status bit after the third of those edges.
- R7: Pin n takes its trigger code from bits [2*(n mod 16)+1 : 2*(n mod 16)] of the low config register when n < 16, and of the high config register otherwise.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R9: When a trigger and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: irq_lo_o is high exactly when some pin in 0–15 has both its status bit and its mask bit at 1, and irq_hi_o does the same for pins 16–31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| pad_i | input | 32 | Pad input levels, asynchronous |
| pad_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_lo_o | output | 1 | Interrupt for pins 0–15 |
| irq_hi_o | output | 1 | Interrupt for pins 16–31 |

## Verification
Directed patterns cover the cases a random mix rarely lines up. A single pad step checks the synchronizer and edge latency one cycle at a time. A level held while software clears it tells set-wins apart from clear-wins. A rise on pin 17 and a fall on pin 31 show that trigger fields are placed per pin in the high config register. A random phase then mixes register writes, pad changes and reads. Its pad values change at random, so edges, levels and clears fall on arbitrary cycles, and a cycle-based bench model predicts each read and each interrupt level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // register select = byte address [4:2]
  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_PAD  = 3'd2,
    SEL_CFGL = 3'd3,
    SEL_CFGH = 3'd4,
    SEL_MASK = 3'd5,
    SEL_STS  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   lvl_i,
  input  logic [2*N-1:0] cfg_i,
  output logic [N-1:0]   hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    trig_e code;
    assign code = trig_e'(cfg_i[2*i +: 2]);
    always_comb begin
      unique case (code)
        TRIG_LOW:  hit_o[i] = ~lvl_i[i];
        TRIG_HIGH: hit_o[i] = lvl_i[i];
        TRIG_RISE: hit_o[i] = lvl_i[i] & ~prev_q[i];
        TRIG_FALL: hit_o[i] = ~lvl_i[i] & prev_q[i];
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else sts_o <= (sts_o & ~clr_i) | hit_i; // set beats clear
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int HALF = N_PINS / 2;

  logic [N_PINS-1:0] data_q, dir_q, mask_q, cfgl_q, cfgh_q;
  logic [N_PINS-1:0] pad_sync, hit, sts_q, clr;
  logic              wr_en;
  reg_sel_e          sel;

  assign sel   = reg_sel_e'(addr_i[4:2]);
  assign wr_en = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      cfgl_q <= '0;
      cfgh_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DATA: data_q <= wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_CFGL: cfgl_q <= wdata_i;
        SEL_CFGH: cfgh_q <= wdata_i;
        SEL_MASK: mask_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_en && sel == SEL_STS) ? wdata_i : '0;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (pad_sync)
  );

  // pin n field at 2n of {high, low}
  gpio_trig_detect #(.N(N_PINS)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pad_sync),
    .cfg_i  ({cfgh_q, cfgl_q}),
    .hit_o  (hit)
  );

  gpio_irq_status #(.N(N_PINS)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr),
    .sts_o  (sts_q)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = data_q;
      SEL_DIR:  rdata_o = dir_q;
      SEL_PAD:  rdata_o = pad_sync;
      SEL_CFGL: rdata_o = cfgl_q;
      SEL_CFGH: rdata_o = cfgh_q;
      SEL_MASK: rdata_o = mask_q;
      SEL_STS:  rdata_o = sts_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
  assign irq_lo_o = |(sts_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi_o = |(sts_q[N_PINS-1:HALF] & mask_q[N_PINS-1:HALF]);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] pad_i,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [N_PINS-1:0] sts_i,
  input logic [N_PINS-1:0] hit_i,
  input logic [N_PINS-1:0] lvl_i
);
  localparam int HALF = N_PINS / 2;

  logic wr_sts, wr_dir, wr_mask;
  logic [1:0] age_q;

  assign wr_sts  = req_i && we_i && addr_i[4:2] == 3'd6;
  assign wr_dir  = req_i && we_i && addr_i[4:2] == 3'd1;
  assign wr_mask = req_i && we_i && addr_i[4:2] == 3'd5;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_PAD_TWO_FLOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> lvl_i == $past(pad_i, 2)); // R4

  AST_OE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pad_oe_o == $past(wdata_i)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sts |=> (sts_i & $past(wdata_i) & ~$past(hit_i)) == '0); // R8

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> (sts_i & $past(hit_i)) == $past(hit_i)); // R9

  AST_STS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_sts && hit_i == '0) |=> $stable(sts_i)); // R8

  AST_LO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask && wdata_i[HALF-1:0] == '0) |=> !irq_lo_o); // R10

  AST_HI_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask && wdata_i[N_PINS-1:HALF] == '0) |=> !irq_hi_o); // R10
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pad_i    (pad_i),
  .pad_oe_o (pad_oe_o),
  .irq_lo_o (irq_lo_o),
  .irq_hi_o (irq_hi_o),
  .sts_i    (sts_q),
  .hit_i    (hit),
  .lvl_i    (pad_sync)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, pad_i = '0, pad_o, pad_oe_o;
  logic        irq_lo_o, irq_hi_o;

  int checks = 0, failures = 0;

  // bench model state
  logic [31:0] m_data = '0, m_dir = '0, m_mask = '0, m_cfgl = '0, m_cfgh = '0;
  logic [31:0] m_sts = '0, m_s1 = '0, m_s2 = '0, m_prev = '0;

  always #2 clk_i = ~clk_i;

  gpio_irq_port dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_i, .pad_o, .pad_oe_o, .irq_lo_o, .irq_hi_o
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_hit(input logic [31:0] lvl, input logic [31:0] prv,
                                        input logic [63:0] cfg);
    logic [31:0] h;
    for (int i = 0; i < 32; i++) begin
      case (cfg[2*i +: 2])
        2'd0: h[i] = ~lvl[i];
        2'd1: h[i] = lvl[i];
        2'd2: h[i] = lvl[i] & ~prv[i];
        default: h[i] = ~lvl[i] & prv[i];
      endcase
    end
    return h;
  endfunction

  function automatic logic [31:0] f_rd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_data;
      3'd1: return m_dir;
      3'd2: return m_s2;
      3'd3: return m_cfgl;
      3'd4: return m_cfgh;
      3'd5: return m_mask;
      3'd6: return m_sts;
      default: return 32'h0;
    endcase
  endfunction

  // one clock edge: predict, wait, commit, check outputs
  task automatic tick();
    logic [31:0] hit, n_sts, clr;
    logic wr;
    wr    = req_i && we_i;
    hit   = f_hit(m_s2, m_prev, {m_cfgh, m_cfgl});
    clr   = (wr && addr_i[4:2] == 3'd6) ? wdata_i : 32'h0;
    n_sts = (m_sts & ~clr) | hit;
    @(posedge clk_i);
    #1;
    if (wr) begin
      case (addr_i[4:2])
        3'd0: m_data = wdata_i;
        3'd1: m_dir  = wdata_i;
        3'd3: m_cfgl = wdata_i;
        3'd4: m_cfgh = wdata_i;
        3'd5: m_mask = wdata_i;
        default: ;
      endcase
    end
    m_sts  = n_sts;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pad_i;
    chk(pad_oe_o, m_dir, "R3 pad_oe_o");
    chk(pad_o, m_data, "R3 pad_o");
    chk({31'h0, irq_lo_o}, {31'h0, |(m_sts[15:0] & m_mask[15:0])}, "R10 irq_lo_o");
    chk({31'h0, irq_hi_o}, {31'h0, |(m_sts[31:16] & m_mask[31:16])}, "R10 irq_hi_o");
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] exp,
                          input logic [31:0] msk, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #0.5;
    chk(rdata_o & msk, exp & msk, tag);
    tick();
    req_i = 1'b0;
  endtask

  task automatic read_model(input logic [4:0] a, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #0.5;
    chk(rdata_o, f_rd(a), tag);
    tick();
    req_i = 1'b0;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk_i);
    pad_i = v;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset values
    #1;
    for (int r = 0; r < 8; r++) begin
      addr_i = 5'(r * 4);
      #0.5;
      chk(rdata_o, 32'h0, "R1 reset register");
    end
    chk(pad_oe_o, 32'h0, "R1 reset pad_oe_o");
    chk(pad_o, 32'h0, "R1 reset pad_o");
    chk({30'h0, irq_hi_o, irq_lo_o}, 32'h0, "R1 reset irq");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 R3: readback and pad drive
    bus_write(5'h00, 32'hA5A5_0F0F);
    bus_write(5'h04, 32'hFFFF_0000);
    bus_read(5'h00, 32'hA5A5_0F0F, '1, "R2 data readback");
    bus_read(5'h04, 32'hFFFF_0000, '1, "R2 dir readback");
    bus_write(5'h14, 32'h0000_0000);
    bus_read(5'h1C, 32'h0, '1, "R2 unmapped address");

    // R4: two-flop latency, independent of data register
    set_pad(32'h1234_5678);
    bus_read(5'h08, 32'h0, '1, "R4 pad level after one edge");
    bus_read(5'h08, 32'h1234_5678, '1, "R4 pad level after two edges");
    bus_write(5'h08, 32'hDEAD_BEEF);
    bus_read(5'h08, 32'h1234_5678, '1, "R2 pad level write ignored");

    // R5 R9: high level on pin 0 keeps status set across a clear
    set_pad(32'h0000_0001);
    bus_write(5'h0C, 32'h0000_0001);
    idle(3);
    bus_write(5'h18, 32'h0000_0001);
    bus_read(5'h18, 32'h1, 32'h1, "R9 set wins over clear");
    bus_read(5'h18, 32'h1, 32'h1, "R5 level reasserts");
    // R8: switch to rising edge, no new edge, clear sticks
    bus_write(5'h0C, 32'h0000_0002);
    bus_write(5'h18, 32'h0000_0001);
    bus_read(5'h18, 32'h0, 32'h1, "R8 write one clears");

    // R6 R7: rising on pin 17, falling on pin 31
    bus_write(5'h10, 32'hC000_0008);
    set_pad(32'h8000_0001);
    idle(4);
    bus_write(5'h18, 32'h8002_0000);
    bus_write(5'h14, 32'h0002_0000);
    set_pad(32'h8002_0001);
    bus_read(5'h18, 32'h0, 32'h0002_0000, "R6 no status after one edge");
    bus_read(5'h18, 32'h0, 32'h0002_0000, "R6 no status after two edges");
    bus_read(5'h18, 32'h0002_0000, 32'h8002_0000, "R7 pin 17 rising in high config");
    chk({31'h0, irq_hi_o}, 32'h1, "R10 irq_hi_o from pin 17");
    chk({31'h0, irq_lo_o}, 32'h0, "R10 irq_lo_o stays low");
    bus_write(5'h18, 32'h0000_0000);
    bus_read(5'h18, 32'h0002_0000, 32'h0002_0000, "R8 write zero keeps bit");
    set_pad(32'h0002_0001);
    idle(2);
    bus_read(5'h18, 32'h8002_0000, 32'h8002_0000, "R6 pin 31 falling");
    bus_write(5'h18, 32'h0002_0000);
    bus_read(5'h18, 32'h0, 32'h0002_0000, "R8 clear pin 17");
    chk({31'h0, irq_hi_o}, 32'h0, "R10 irq_hi_o drops after clear");

    // random mix against the model
    for (int it = 0; it < 1500; it++) begin
      case ($urandom_range(0, 3))
        0: bus_write(5'($urandom_range(0, 7) * 4), $urandom());
        1: set_pad($urandom());
        2: read_model(5'($urandom_range(0, 7) * 4), "R2 R5 R6 R8 random read");
        default: idle($urandom_range(1, 3));
      endcase
    end
    for (int r = 0; r < 8; r++) read_model(5'(r * 4), "R2 final read");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule